// File: doc/BRIEF.md
# Sequential Lifting Wavelet Datapath

This block computes one decomposition level of a one-dimensional wavelet transform from a four-stage lifting factorisation. Each accepted start strobe delivers one even/odd pair of 10-bit signed samples. A single arithmetic core evaluates `W = X + Bi*Y + Bj*Z` once per clock. The block cycles that core through five dependent steps, in a fixed order, and produces one approximation word and one detail word. The approximation and detail words refer to earlier sample pairs, so the two non-causal lifting stages become causal. The multiplier coefficients are fixed constants. The final normalising gains are left to whatever consumes the coefficients.

The steps, with `h`/`f` the new even/odd samples and `Pp`, `Qp`, `Rp`, `Fp` the history words left by the previous pair, are:
1. `P = h + B0*f`
2. `Q = Fp + B1*P + B2*Pp`
3. `R = Pp + B3*Q + B4*Qp`
4. `A = Q + B5*R + B6*Rp`
5. `D = Rp + B7*A`

After step 5 the history becomes {P, Q, R, f}. The history is four words and is visible on a store port at all times. A load port replaces it, so an outside scheduler can interleave several channels or levels through one instance by saving and restoring contexts between pairs.

Top module: `lift_wavelet_core`

## Requirements
- R1: For each accepted pair, the block evaluates the five steps above, in that order, using the history left by the previous pair. approx_out carries A and detail_out carries D.
- R2: Each product `Bk*Y` is arithmetically shifted right by 3, which floors it, and is then saturated to [-512, 511]. Each step result is also saturated to [-512, 511]. The two saturation points are distinct: with history {f=-512, r=0, q=-400, p=0} and the input pair (0, 0), the new R is 461.
- R3: The coefficients are signed 5-bit values with 3 fractional bits: B0..B7 = 3, -1, -3, -11, 1, 3, 1, -8 (in eighths). Steps 1 and 5 use a zero second coefficient.
- R4: Take the clock edge that accepts start as edge 0. approx_valid is a one-cycle pulse set at edge 4. detail_valid is a one-cycle pulse set at edge 5. The two strobes are never high together.
- R5: busy is high for exactly five cycles after an accepted start. A start sampled while busy is high is ignored, and the data presented with it is never used.
- R6: After reset, the first two pairs produce no valid strobes. Strobes are produced from the third pair on.
- R7: ctx_out shows the history as {f[39:30], r[29:20], q[19:10], p[9:0]}. After reset it is all zero. After each pair it is updated to {f, R, Q, P} of that pair.
- R8: ctx_load sampled while busy is low copies ctx_in into the history. The history then counts as filled, so the next pair's strobes are valid. ctx_load sampled while busy is high is ignored. If ctx_load and start arrive in the same idle cycle, the load wins and the start is dropped.
- R9: While rst_n is low, busy, approx_valid, detail_valid and ctx_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept one sample pair when idle |
| even_in | input | 10 | Even sample h, signed |
| odd_in | input | 10 | Odd sample f, signed |
| busy | output | 1 | Five-step sequence in progress |
| approx_out | output | 10 | Approximation coefficient, signed |
| approx_valid | output | 1 | One-cycle strobe for approx_out |
| detail_out | output | 10 | Detail coefficient, signed |
| detail_valid | output | 1 | One-cycle strobe for detail_out |
| ctx_load | input | 1 | Replace history from ctx_in when idle |
| ctx_in | input | 40 | History to load, packed {f, r, q, p} |
| ctx_out | output | 40 | Current history, packed {f, r, q, p} |

## Verification
A vector stream of mixed-sign, small and full-scale pairs is run from reset. This separates correct step ordering and history reuse from a datapath that only looks at the current pair, and it shows that the first two pairs stay unflagged. A single-coefficient probe (even 0, odd 8) isolates B0. Full-scale inputs show that step results are clamped. A loaded context with a -512 odd history tells product saturation apart from saturation of the sum alone. Directed sequences cover overlapping start and load requests during a busy window, a load issued together with a start, and a context swapped out and restored, to show that the history really carries channel state.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

  localparam int DATA_W  = 10;
  localparam int COEF_W  = 5;
  localparam int FRAC_W  = 3;
  localparam int N_COEF  = 8;
  localparam int SUM_W   = DATA_W + COEF_W + 1;
  localparam int CTX_W   = 4 * DATA_W;
  localparam int WORD_MAX = (1 <<< (DATA_W - 1)) - 1;
  localparam int WORD_MIN = -(1 <<< (DATA_W - 1));

  typedef logic signed [DATA_W-1:0] word_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [SUM_W-1:0]  wide_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_P    = 3'd1,
    ST_Q    = 3'd2,
    ST_R    = 3'd3,
    ST_A    = 3'd4,
    ST_D    = 3'd5
  } step_e;

  typedef struct packed {
    word_t f;
    word_t r;
    word_t q;
    word_t p;
  } ctx_t;

  // Hardwired lifting coefficients, signed with FRAC_W fractional bits.
  function automatic coef_t coef_rom(input int idx);
    case (idx)
      0:       return coef_t'(3);
      1:       return coef_t'(-1);
      2:       return coef_t'(-3);
      3:       return coef_t'(-11);
      4:       return coef_t'(1);
      5:       return coef_t'(3);
      6:       return coef_t'(1);
      7:       return coef_t'(-8);
      default: return coef_t'(0);
    endcase
  endfunction

  function automatic wide_t widen(input word_t v);
    return wide_t'(v);
  endfunction

  // Clamp a wide signed value into the data word range.
  function automatic word_t clip_word(input wide_t v);
    if (v > wide_t'(WORD_MAX)) return word_t'(WORD_MAX);
    if (v < wide_t'(WORD_MIN)) return word_t'(WORD_MIN);
    return v[DATA_W-1:0];
  endfunction

  // Product, floored by the fractional shift, then clamped.
  function automatic word_t scaled_product(input coef_t b, input word_t y);
    wide_t be;
    wide_t ye;
    wide_t pr;
    be = wide_t'(b);
    ye = wide_t'(y);
    pr = be * ye;
    return clip_word(pr >>> FRAC_W);
  endfunction

  // One lifting step W = X + Bi*Y + Bj*Z with all clamps applied.
  function automatic word_t lift_step(input word_t x, input coef_t bi, input word_t y,
                                      input coef_t bj, input word_t z);
    wide_t s;
    s = widen(x) + widen(scaled_product(bi, y)) + widen(scaled_product(bj, z));
    return clip_word(s);
  endfunction

endpackage

// File: rtl/lwt_mac.sv
module lwt_mac
  import lwt_pkg::*;
(
  input  word_t x_i,
  input  coef_t bi_i,
  input  word_t y_i,
  input  coef_t bj_i,
  input  word_t z_i,
  output word_t prod_y_o,
  output word_t prod_z_o,
  output word_t w_o
);

  // Two multipliers in parallel, then two adders in series.
  assign prod_y_o = scaled_product(bi_i, y_i);
  assign prod_z_o = scaled_product(bj_i, z_i);
  assign w_o      = lift_step(x_i, bi_i, y_i, bj_i, z_i);

endmodule

// File: rtl/lwt_seq.sv
module lwt_seq
  import lwt_pkg::*;
#(
  parameter int FILL_PAIRS = 2
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  load_i,
  output step_e step_o,
  output logic  busy_o,
  output logic  acc_start_o,
  output logic  acc_load_o,
  output logic  commit_o,
  output logic  filled_o
);

  localparam int FILL_W = $clog2(FILL_PAIRS + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(FILL_PAIRS);

  step_e             step_q;
  step_e             step_d;
  logic [FILL_W-1:0] fill_q;

  assign busy_o      = (step_q != ST_IDLE);
  assign acc_load_o  = load_i && !busy_o;
  assign acc_start_o = start_i && !busy_o && !load_i;
  assign commit_o    = (step_q == ST_D);
  assign filled_o    = (fill_q == FILL_FULL);
  assign step_o      = step_q;

  always_comb begin
    case (step_q)
      ST_IDLE: step_d = acc_start_o ? ST_P : ST_IDLE;
      ST_P:    step_d = ST_Q;
      ST_Q:    step_d = ST_R;
      ST_R:    step_d = ST_A;
      ST_A:    step_d = ST_D;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      fill_q <= '0;
    end else begin
      step_q <= step_d;
      if (acc_load_o) begin
        fill_q <= FILL_FULL;
      end else if (commit_o && !filled_o) begin
        fill_q <= fill_q + FILL_W'(1);
      end
    end
  end

endmodule

// File: rtl/lwt_hist.sv
module lwt_hist
  import lwt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  ctx_t load_val_i,
  input  logic commit_i,
  input  ctx_t commit_val_i,
  output ctx_t hist_o
);

  ctx_t hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (load_i) begin
      hist_q <= load_val_i;
    end else if (commit_i) begin
      hist_q <= commit_val_i;
    end
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/lift_wavelet_core.sv
module lift_wavelet_core
  import lwt_pkg::*;
#(
  parameter int FILL_PAIRS = 2
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] even_in,
  input  logic signed [DATA_W-1:0] odd_in,
  output logic                     busy,
  output logic signed [DATA_W-1:0] approx_out,
  output logic                     approx_valid,
  output logic signed [DATA_W-1:0] detail_out,
  output logic                     detail_valid,
  input  logic                     ctx_load,
  input  logic [CTX_W-1:0]         ctx_in,
  output logic [CTX_W-1:0]         ctx_out
);

  step_e step;
  logic  acc_start;
  logic  acc_load;
  logic  commit;
  logic  filled;

  word_t h_l, f_l;
  word_t wp, wq, wr, wa;
  word_t op_x, op_y, op_z;
  coef_t op_bi, op_bj;
  word_t core_w;
  word_t core_py, core_pz;
  ctx_t  hist;
  ctx_t  hist_next;

  lwt_seq #(.FILL_PAIRS(FILL_PAIRS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .load_i      (ctx_load),
    .step_o      (step),
    .busy_o      (busy),
    .acc_start_o (acc_start),
    .acc_load_o  (acc_load),
    .commit_o    (commit),
    .filled_o    (filled)
  );

  // Operand routing into the shared core, one lifting step per cycle.
  always_comb begin
    op_x  = '0;
    op_y  = '0;
    op_z  = '0;
    op_bi = '0;
    op_bj = '0;
    case (step)
      ST_P: begin
        op_x = h_l;    op_bi = coef_rom(0); op_y = f_l;
      end
      ST_Q: begin
        op_x = hist.f; op_bi = coef_rom(1); op_y = wp;
        op_bj = coef_rom(2); op_z = hist.p;
      end
      ST_R: begin
        op_x = hist.p; op_bi = coef_rom(3); op_y = wq;
        op_bj = coef_rom(4); op_z = hist.q;
      end
      ST_A: begin
        op_x = wq;     op_bi = coef_rom(5); op_y = wr;
        op_bj = coef_rom(6); op_z = hist.r;
      end
      ST_D: begin
        op_x = hist.r; op_bi = coef_rom(7); op_y = wa;
      end
      default: ;
    endcase
  end

  lwt_mac u_mac (
    .x_i      (op_x),
    .bi_i     (op_bi),
    .y_i      (op_y),
    .bj_i     (op_bj),
    .z_i      (op_z),
    .prod_y_o (core_py),
    .prod_z_o (core_pz),
    .w_o      (core_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_l          <= '0;
      f_l          <= '0;
      wp           <= '0;
      wq           <= '0;
      wr           <= '0;
      wa           <= '0;
      approx_out   <= '0;
      approx_valid <= 1'b0;
      detail_out   <= '0;
      detail_valid <= 1'b0;
    end else begin
      approx_valid <= 1'b0;
      detail_valid <= 1'b0;
      if (acc_start) begin
        h_l <= even_in;
        f_l <= odd_in;
      end
      case (step)
        ST_P: wp <= core_w;
        ST_Q: wq <= core_w;
        ST_R: wr <= core_w;
        ST_A: begin
          wa           <= core_w;
          approx_out   <= core_w;
          approx_valid <= filled;
        end
        ST_D: begin
          detail_out   <= core_w;
          detail_valid <= filled;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    hist_next.f = f_l;
    hist_next.r = wr;
    hist_next.q = wq;
    hist_next.p = wp;
  end

  lwt_hist u_hist (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (acc_load),
    .load_val_i   (ctx_t'(ctx_in)),
    .commit_i     (commit),
    .commit_val_i (hist_next),
    .hist_o       (hist)
  );

  assign ctx_out = hist;

endmodule

// File: rtl/lwt_checker.sv
module lwt_checker
  import lwt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ctx_load,
  input logic [CTX_W-1:0] ctx_in,
  input logic             busy,
  input logic             approx_valid,
  input logic             detail_valid,
  input logic [CTX_W-1:0] ctx_out,
  input logic             commit
);

  logic [2:0] run_q;
  logic [1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seen_q <= '0;
    end else begin
      if (busy) run_q <= (run_q == 3'd7) ? run_q : run_q + 3'd1;
      else      run_q <= '0;
      if (ctx_load && !busy)          seen_q <= 2'd2;
      else if (commit && seen_q != 2) seen_q <= seen_q + 2'd1;
    end
  end

  assert_start_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !ctx_load) |=> busy);

  assert_busy_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 3'd5));

  assert_detail_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    approx_valid |=> detail_valid);

  assert_valid_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({approx_valid, detail_valid}));

  assert_detail_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    detail_valid |-> !busy);

  assert_ctx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> $stable(ctx_out));

  assert_load_apply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load && !busy) |=> (ctx_out == $past(ctx_in)));

  assert_fill_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    approx_valid |-> (seen_q == 2'd2));

endmodule

bind lift_wavelet_core lwt_checker u_lwt_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .ctx_load     (ctx_load),
  .ctx_in       (ctx_in),
  .busy         (busy),
  .approx_valid (approx_valid),
  .detail_valid (detail_valid),
  .ctx_out      (ctx_out),
  .commit       (commit)
);

// File: tb/test_lift_wavelet_core.sv
`timescale 1ns/1ps
module test_lift_wavelet_core;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic signed [9:0]  even_in = '0;
  logic signed [9:0]  odd_in = '0;
  logic               busy;
  logic signed [9:0]  approx_out;
  logic               approx_valid;
  logic signed [9:0]  detail_out;
  logic               detail_valid;
  logic               ctx_load = 1'b0;
  logic [39:0]        ctx_in = '0;
  logic [39:0]        ctx_out;

  int total = 0;
  int fails = 0;
  bit done = 0;

  int mp = 0, mq = 0, mr = 0, mf = 0, mfill = 0;
  int last_a = 0, last_d = 0;

  localparam int KB [8] = '{3, -1, -3, -11, 1, 3, 1, -8};
  localparam int NV = 10;
  localparam int VEC [NV][2] = '{
    '{100, -40}, '{-200, 37}, '{511, 511}, '{-512, -512}, '{0, 8},
    '{17, -300}, '{-1, 1}, '{250, 250}, '{-77, 400}, '{3, -5}
  };

  always #4 clk = ~clk;

  lift_wavelet_core i_lift_wavelet_core (
    .clk(clk), .rst_n(rst_n), .start(start), .even_in(even_in), .odd_in(odd_in),
    .busy(busy), .approx_out(approx_out), .approx_valid(approx_valid),
    .detail_out(detail_out), .detail_valid(detail_valid),
    .ctx_load(ctx_load), .ctx_in(ctx_in), .ctx_out(ctx_out)
  );

  function automatic int floor8(int v);
    if (v >= 0) return v / 8;
    return -((-v + 7) / 8);
  endfunction

  function automatic int lim(int v);
    return (v > 511) ? 511 : ((v < -512) ? -512 : v);
  endfunction

  function automatic int mulq(int b, int y);
    return lim(floor8(b * y));
  endfunction

  function automatic int stp(int x, int bi, int y, int bj, int z);
    return lim(x + mulq(bi, y) + mulq(bj, z));
  endfunction

  function automatic logic [39:0] pack(int f, int r, int q, int p);
    return {10'(f), 10'(r), 10'(q), 10'(p)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Model of one pair from the requirements; updates the model history.
  task automatic model_pair(input int h, input int f);
    int p, q, r, a, d;
    p = stp(h, KB[0], f, 0, 0);
    q = stp(mf, KB[1], p, KB[2], mp);
    r = stp(mp, KB[3], q, KB[4], mq);
    a = stp(q, KB[5], r, KB[6], mr);
    d = stp(mr, KB[7], a, 0, 0);
    last_a = a; last_d = d;
    mp = p; mq = q; mr = r; mf = f;
  endtask

  // intrude: 1 = extra start during busy, 2 = ctx_load during busy
  task automatic run_pair(input int h, input int f, input int intrude);
    bit exp_valid;
    exp_valid = (mfill >= 2);
    @(negedge clk);
    even_in = 10'(h); odd_in = 10'(f); start = 1'b1;
    @(negedge clk);                    // after edge 0
    start = 1'b0;
    chk("R5 busy after start", int'(busy), 1);
    if (intrude == 1) begin
      start = 1'b1; even_in = 10'(-h); odd_in = 10'(h);
    end
    if (intrude == 2) begin
      ctx_load = 1'b1; ctx_in = 40'h5A5A5A5A5A;
    end
    repeat (3) @(negedge clk);         // after edges 1..3
    chk("R4 approx not early", int'(approx_valid), 0);
    @(negedge clk);                    // after edge 4
    start = 1'b0; ctx_load = 1'b0;
    model_pair(h, f);
    chk("R6 approx strobe gating", int'(approx_valid), int'(exp_valid));
    if (exp_valid) chk("R1 approx value", int'(approx_out), last_a);
    chk("R5 busy in fifth cycle", int'(busy), 1);
    @(negedge clk);                    // after edge 5
    chk("R6 detail strobe gating", int'(detail_valid), int'(exp_valid));
    if (exp_valid) chk("R1 detail value", int'(detail_out), last_d);
    chk("R4 approx pulse width", int'(approx_valid), 0);
    chk("R5 busy cleared", int'(busy), 0);
    chk("R7 ctx after pair", int'(ctx_out == pack(mf, mr, mq, mp)), 1);
    if (mfill < 2) mfill++;
  endtask

  task automatic load_ctx(input int f, input int r, input int q, input int p, input bit with_start);
    @(negedge clk);
    ctx_load = 1'b1; ctx_in = pack(f, r, q, p);
    start = with_start; even_in = 10'sd55; odd_in = 10'sd66;
    @(negedge clk);
    ctx_load = 1'b0; start = 1'b0;
    chk("R8 ctx loaded", int'(ctx_out == pack(f, r, q, p)), 1);
    if (with_start) chk("R8 load beats start", int'(busy), 0);
    mf = f; mr = r; mq = q; mp = p; mfill = 2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [39:0] saved;
    int sp, sq, sr, sf;
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", int'(busy), 0);
    chk("R9 approx_valid in reset", int'(approx_valid), 0);
    chk("R9 detail_valid in reset", int'(detail_valid), 0);
    chk("R9 ctx in reset", int'(ctx_out == 40'd0), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: coefficient B0 isolated: P = floor(3*8/8) = 3
    run_pair(0, 8, 0);
    chk("R3 B0 product", int'($signed(ctx_out[9:0])), 3);
    chk("R7 odd field", int'($signed(ctx_out[39:30])), 8);

    // Vector walk, expected from the model
    for (int i = 0; i < NV; i++) run_pair(VEC[i][0], VEC[i][1], 0);

    // R2: step saturation on full-scale input
    run_pair(511, 511, 0);
    chk("R2 step result clamp", int'($signed(ctx_out[9:0])), 511);

    // R5: start while busy ignored
    run_pair(123, -45, 1);
    @(negedge clk);
    chk("R5 no restart from held start", int'(busy), 0);

    // R8: load while busy ignored (checked inside run_pair against model)
    run_pair(-60, 90, 2);

    // R2: product saturation distinguished from sum saturation
    load_ctx(-512, 0, -400, 0, 0);
    run_pair(0, 0, 0);
    chk("R2 product clamp", int'($signed(ctx_out[29:20])), 461);

    // R8: context swap out, run another channel, restore
    saved = ctx_out; sp = mp; sq = mq; sr = mr; sf = mf;
    load_ctx(10, -20, 30, -40, 1);
    run_pair(200, -100, 0);
    load_ctx($signed(saved[39:30]), $signed(saved[29:20]), $signed(saved[19:10]),
             $signed(saved[9:0]), 0);
    chk("R8 restored model", int'(mp == sp && mq == sq && mr == sr && mf == sf), 1);
    run_pair(-7, 9, 0);

    // R9: reset mid-stream clears outputs and history
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 ctx after reset", int'(ctx_out == 40'd0), 1);
    rst_n = 1'b1;
    mp = 0; mq = 0; mr = 0; mf = 0; mfill = 0;
    run_pair(40, 40, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule